// File: doc/BRIEF.md
# Cache Maintenance Command Sequencer

This block sits beside a simple in-order core and turns one coprocessor register write, aimed at the cache-operations register, into a sequence of handshakes. It decodes the secondary register field and the second opcode field of the write. From them it issues a cache command to the instruction cache, the data cache, or both. It can also hold the core in a store barrier until the write buffer is empty. A third outcome drains the write buffer and then parks the core in a low-power wait.

The core stall output is high for the whole of any accepted operation. A low-power wait ends when an IRQ, an FIQ or a debug request arrives. At that point the block reports completion together with a return link equal to the command address plus eight. The block then returns to idle so that normal exception entry can proceed. The cache arrays, the write buffer and the exception logic sit outside the block and are reached only through request, done and status ports.

Top module: `cmaint_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, and in the cycle that follows, `core_stall`, `low_power`, `ic_req`, `dc_req`, `wb_drain_req`, `fill_req` and `wake_ack` are all 0.
- R2: A command accepted in idle with (crm, op2) = (5,0), (5,1), (5,2) or (13,1) raises `ic_req` for exactly the next cycle. In that cycle `ic_kind` is 0, 1, 2 or 3 respectively, meaning whole cache, one entry by virtual address, one entry by set/way, or line prefetch.
- R3: (6,0) and (6,1) raise `dc_req` for exactly the next cycle with `dc_kind` 0 (whole cache) or 1 (one entry by virtual address). (7,0) raises `ic_req` with `ic_kind` 0 and `dc_req` with `dc_kind` 0 in the same cycle.
- R4: During a request, `op_arg` is 0 for every whole-cache operation, whatever `cmd_data` holds. For every single-entry or prefetch operation it equals `cmd_data`.
- R5: After a cache request, `core_stall` stays high until every requested cache has pulsed its done signal. Done signals may arrive in different cycles. `core_stall` falls two cycles after the last of them is sampled.
- R6: For a prefetch, `fill_req` pulses for one cycle, with `op_arg` holding the address, in the cycle after `ic_done`. It does so only if `ic_miss` and `ic_cacheable` were both 1 when `ic_done` was sampled; otherwise `fill_req` stays 0.
- R7: The barrier (crm 10, op2 4) keeps `wb_drain_req` and `core_stall` high while `wb_empty` is 0. Once `wb_empty` is sampled high, `wb_drain_req` drops in the next cycle and `core_stall` drops one cycle after that.
- R8: The wait command (crm 0, op2 4) first drains like the barrier. `low_power` stays 0 while the buffer is not empty, and rises in the cycle after `wb_empty` is sampled high with no wake pending.
- R9: While `low_power` is high, any of `irq`, `fiq` or `dbg_req` ends it in the next cycle. In that same cycle `wake_ack` pulses and `wake_link` equals the command's `cmd_pc` plus 8, modulo 2^AW. `core_stall` falls one cycle later.
- R10: A wake event seen during the drain phase of a wait is remembered. `low_power` is then never raised, and `wake_ack` pulses in the cycle after `wb_empty` is sampled high.
- R11: Any (crm, op2) pair not listed in R2, R3, R7 or R8 produces no stall, no request and no low-power indication.
- R12: `cmd_valid` is ignored while `core_stall` is high; such a write issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Register write to the cache-operations register this cycle |
| cmd_crm | input | 4 | Secondary register field of the write |
| cmd_op2 | input | 3 | Second opcode field of the write |
| cmd_data | input | DW | Data operand of the write |
| cmd_pc | input | AW | Address of the writing instruction |
| core_stall | output | 1 | Holds the core while an operation is in progress |
| ic_req | output | 1 | One-cycle instruction-cache command |
| ic_kind | output | 2 | Instruction-cache command type |
| dc_req | output | 1 | One-cycle data-cache command |
| dc_kind | output | 1 | Data-cache command type |
| op_arg | output | DW | Operand for cache commands and line fill |
| ic_done | input | 1 | Instruction cache finished its command |
| ic_miss | input | 1 | Prefetch lookup missed (valid with ic_done) |
| ic_cacheable | input | 1 | Prefetch region is cacheable (valid with ic_done) |
| dc_done | input | 1 | Data cache finished its command |
| fill_req | output | 1 | One-cycle line-fill request after a prefetch miss |
| wb_drain_req | output | 1 | Asks the write buffer to empty itself |
| wb_empty | input | 1 | Write buffer holds no stores |
| irq | input | 1 | Interrupt request |
| fiq | input | 1 | Fast interrupt request |
| dbg_req | input | 1 | Debug request |
| low_power | output | 1 | Core is in the low-power wait |
| wake_ack | output | 1 | One-cycle completion pulse of a wait |
| wake_link | output | AW | Return link for exception entry |

## Verification
The bench builds the block with DW = 16 and AW = 16. The narrow address makes it cheap to place a wait command at 0xFFFC, so the plus-eight link must wrap to 0x0004. Narrow data lets each table row carry a distinct operand, which shows that whole-cache rows present zero while single-entry rows pass the value through. Corner cases cover split done arrivals, all three prefetch outcomes, each wake source, and a wake that lands during the drain.

// File: rtl/cmaint_pkg.sv
// Shared codes and types for the cache maintenance sequencer.
// Assumes the secondary register field is 4 bits and the second opcode 3 bits.
package cmaint_pkg;

    localparam int CRM_W = 4;
    localparam int OP2_W = 3;

    // Operation selector codes, each one a {crm, op2} pair
    localparam logic [CRM_W+OP2_W-1:0] SEL_BOTH_ALL  = {4'd7,  3'd0};
    localparam logic [CRM_W+OP2_W-1:0] SEL_IC_ALL    = {4'd5,  3'd0};
    localparam logic [CRM_W+OP2_W-1:0] SEL_IC_VA     = {4'd5,  3'd1};
    localparam logic [CRM_W+OP2_W-1:0] SEL_IC_SW     = {4'd5,  3'd2};
    localparam logic [CRM_W+OP2_W-1:0] SEL_IC_PF     = {4'd13, 3'd1};
    localparam logic [CRM_W+OP2_W-1:0] SEL_DC_ALL    = {4'd6,  3'd0};
    localparam logic [CRM_W+OP2_W-1:0] SEL_DC_VA     = {4'd6,  3'd1};
    localparam logic [CRM_W+OP2_W-1:0] SEL_BARRIER   = {4'd10, 3'd4};
    localparam logic [CRM_W+OP2_W-1:0] SEL_WAIT      = {4'd0,  3'd4};

    typedef enum logic [2:0] {
        ST_IDLE, ST_ISSUE, ST_WAIT_ACK, ST_DRAIN, ST_SLEEP, ST_DONE
    } seq_state_e;

    localparam logic [1:0] ICK_ALL = 2'd0;
    localparam logic [1:0] ICK_VA  = 2'd1;
    localparam logic [1:0] ICK_SW  = 2'd2;
    localparam logic [1:0] ICK_PF  = 2'd3;

    typedef struct packed {
        logic       use_ic;
        logic       use_dc;
        logic [1:0] ic_kind;
        logic       dc_kind;
        logic       zero_arg;
        logic       barrier;
        logic       sleep;
    } op_dec_t;

endpackage

// File: rtl/cmaint_decode.sv
// Combinational decoder from {crm, op2} to an operation descriptor.
// Assumes nothing about timing; unknown pairs decode to all zeros (no-op).
module cmaint_decode
    import cmaint_pkg::*;
(
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] op2,
    output op_dec_t          dec
);

    // Map each selector pair onto its cache targets and command kinds
    always_comb begin
        dec = '0;
        case ({crm, op2})
            SEL_BOTH_ALL: begin
                dec.use_ic = 1'b1; dec.use_dc = 1'b1; dec.zero_arg = 1'b1;
            end
            SEL_IC_ALL:  begin dec.use_ic = 1'b1; dec.zero_arg = 1'b1; end
            SEL_IC_VA:   begin dec.use_ic = 1'b1; dec.ic_kind = ICK_VA; end
            SEL_IC_SW:   begin dec.use_ic = 1'b1; dec.ic_kind = ICK_SW; end
            SEL_IC_PF:   begin dec.use_ic = 1'b1; dec.ic_kind = ICK_PF; end
            SEL_DC_ALL:  begin dec.use_dc = 1'b1; dec.zero_arg = 1'b1; end
            SEL_DC_VA:   begin dec.use_dc = 1'b1; dec.dc_kind = 1'b1; end
            SEL_BARRIER: dec.barrier = 1'b1;
            SEL_WAIT:    dec.sleep   = 1'b1;
            default:     dec = '0;
        endcase
    end

endmodule

// File: rtl/cmaint_link.sv
// Captures the return link (command address plus a fixed offset) when a
// wait command is accepted. Assumes wrap-around modulo 2^AW is wanted.
module cmaint_link #(
    parameter int AW     = 32,
    parameter int OFFSET = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [AW-1:0] pc,
    output logic [AW-1:0] link
);

    localparam logic [AW-1:0] OFS = AW'(OFFSET);

    // Hold the link from acceptance until the next wait command
    always_ff @(posedge clk) begin
        if (!rst_n)       link <= '0;
        else if (capture) link <= pc + OFS;
    end

endmodule

// File: rtl/cmaint_fsm.sv
// Sequencing state machine: issue, wait for done, drain, sleep, complete.
// Assumes done signals are sampled only from the cycle after the request
// pulse and that wake sources are synchronous to clk.
module cmaint_fsm
    import cmaint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  op_dec_t    dec,
    input  logic       ic_done,
    input  logic       ic_miss,
    input  logic       ic_cacheable,
    input  logic       dc_done,
    input  logic       wb_empty,
    input  logic       wake,
    output logic       accept,
    output logic       core_stall,
    output logic       ic_req,
    output logic [1:0] ic_kind,
    output logic       dc_req,
    output logic       dc_kind,
    output logic       fill_req,
    output logic       wb_drain_req,
    output logic       low_power,
    output logic       wake_ack
);

    seq_state_e state;
    op_dec_t    op_q;
    logic       ic_seen, dc_seen, fill_pend, wake_seen;
    logic       ic_now, dc_now;

    assign accept = cmd_valid && (state == ST_IDLE);
    assign ic_now = ic_seen || ic_done;
    assign dc_now = dc_seen || dc_done;

    // Advance the sequence and track done, fill and wake flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            op_q      <= '0;
            ic_seen   <= 1'b0;
            dc_seen   <= 1'b0;
            fill_pend <= 1'b0;
            wake_seen <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    ic_seen   <= 1'b0;
                    dc_seen   <= 1'b0;
                    fill_pend <= 1'b0;
                    wake_seen <= 1'b0;
                    if (cmd_valid) begin
                        op_q <= dec;
                        if (dec.use_ic || dec.use_dc)     state <= ST_ISSUE;
                        else if (dec.barrier || dec.sleep) state <= ST_DRAIN;
                    end
                end
                ST_ISSUE: state <= ST_WAIT_ACK;
                ST_WAIT_ACK: begin
                    ic_seen <= ic_now;
                    dc_seen <= dc_now;
                    if (ic_done && op_q.use_ic && op_q.ic_kind == ICK_PF
                        && ic_miss && ic_cacheable)
                        fill_pend <= 1'b1;
                    if ((!op_q.use_ic || ic_now) && (!op_q.use_dc || dc_now))
                        state <= ST_DONE;
                end
                ST_DRAIN: begin
                    if (op_q.sleep && wake) wake_seen <= 1'b1;
                    if (wb_empty) begin
                        if (!op_q.sleep || wake_seen || wake) state <= ST_DONE;
                        else                                  state <= ST_SLEEP;
                    end
                end
                ST_SLEEP: if (wake) state <= ST_DONE;
                ST_DONE:  state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Moore outputs decoded from the current state and held operation
    always_comb begin
        core_stall   = (state != ST_IDLE);
        ic_req       = (state == ST_ISSUE) && op_q.use_ic;
        dc_req       = (state == ST_ISSUE) && op_q.use_dc;
        ic_kind      = op_q.ic_kind;
        dc_kind      = op_q.dc_kind;
        wb_drain_req = (state == ST_DRAIN);
        low_power    = (state == ST_SLEEP);
        fill_req     = (state == ST_DONE) && fill_pend;
        wake_ack     = (state == ST_DONE) && op_q.sleep;
    end

endmodule

// File: rtl/cmaint_seq.sv
// Top of the cache maintenance sequencer. Decodes one register write and
// drives cache, write-buffer and low-power handshakes; stalls the core while
// busy. Assumes the core presents at most one write while not stalled.
module cmaint_seq
    import cmaint_pkg::*;
#(
    parameter int DW          = 32,
    parameter int AW          = 32,
    parameter int LINK_OFFSET = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_crm,
    input  logic [2:0]    cmd_op2,
    input  logic [DW-1:0] cmd_data,
    input  logic [AW-1:0] cmd_pc,
    output logic          core_stall,
    output logic          ic_req,
    output logic [1:0]    ic_kind,
    output logic          dc_req,
    output logic          dc_kind,
    output logic [DW-1:0] op_arg,
    input  logic          ic_done,
    input  logic          ic_miss,
    input  logic          ic_cacheable,
    input  logic          dc_done,
    output logic          fill_req,
    output logic          wb_drain_req,
    input  logic          wb_empty,
    input  logic          irq,
    input  logic          fiq,
    input  logic          dbg_req,
    output logic          low_power,
    output logic          wake_ack,
    output logic [AW-1:0] wake_link
);

    op_dec_t dec;
    logic    accept;
    logic    wake;

    assign wake = irq || fiq || dbg_req;

    cmaint_decode u_dec (
        .crm (cmd_crm),
        .op2 (cmd_op2),
        .dec (dec)
    );

    cmaint_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .dec          (dec),
        .ic_done      (ic_done),
        .ic_miss      (ic_miss),
        .ic_cacheable (ic_cacheable),
        .dc_done      (dc_done),
        .wb_empty     (wb_empty),
        .wake         (wake),
        .accept       (accept),
        .core_stall   (core_stall),
        .ic_req       (ic_req),
        .ic_kind      (ic_kind),
        .dc_req       (dc_req),
        .dc_kind      (dc_kind),
        .fill_req     (fill_req),
        .wb_drain_req (wb_drain_req),
        .low_power    (low_power),
        .wake_ack     (wake_ack)
    );

    cmaint_link #(.AW(AW), .OFFSET(LINK_OFFSET)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (accept && dec.sleep),
        .pc      (cmd_pc),
        .link    (wake_link)
    );

    // Latch the operand at acceptance, forced to zero for whole-cache commands
    always_ff @(posedge clk) begin
        if (!rst_n)      op_arg <= '0;
        else if (accept) op_arg <= dec.zero_arg ? '0 : cmd_data;
    end

endmodule

// File: rtl/cmaint_seq_chk.sv
// Property checker for cmaint_seq, bound to every instance of the top.
// Assumes only the top's ports; holds from reset onward.
module cmaint_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic core_stall,
    input logic ic_req,
    input logic dc_req,
    input logic fill_req,
    input logic wb_drain_req,
    input logic wb_empty,
    input logic irq,
    input logic fiq,
    input logic dbg_req,
    input logic low_power,
    input logic wake_ack
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !core_stall && !low_power && !ic_req && !dc_req
                   && !wb_drain_req && !fill_req && !wake_ack);

    a_r2_ic_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ic_req |=> !ic_req);

    a_r3_dc_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dc_req |=> !dc_req);

    a_r5_req_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_req || dc_req) |-> core_stall);

    a_r6_fill_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> core_stall && !ic_req);

    a_r7_drain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        wb_drain_req && !wb_empty |=> wb_drain_req && core_stall);

    a_r8_sleep_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_power) |-> $past(wb_empty) && $past(wb_drain_req));

    a_r9_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
        low_power && !(irq || fiq || dbg_req) |=> low_power && core_stall);

    a_r9_wake_exits: assert property (@(posedge clk) disable iff (!rst_n)
        low_power && (irq || fiq || dbg_req) |=> !low_power && wake_ack);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !core_stall |-> !ic_req && !dc_req && !low_power && !wb_drain_req);

endmodule

bind cmaint_seq cmaint_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_stall   (core_stall),
    .ic_req       (ic_req),
    .dc_req       (dc_req),
    .fill_req     (fill_req),
    .wb_drain_req (wb_drain_req),
    .wb_empty     (wb_empty),
    .irq          (irq),
    .fiq          (fiq),
    .dbg_req      (dbg_req),
    .low_power    (low_power),
    .wake_ack     (wake_ack)
);

// File: tb/sim_cmaint_seq.sv
module sim_cmaint_seq;

    localparam int DW = 16;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [3:0]    cmd_crm = '0;
    logic [2:0]    cmd_op2 = '0;
    logic [DW-1:0] cmd_data = '0;
    logic [AW-1:0] cmd_pc = '0;
    logic          ic_done = 1'b0, ic_miss = 1'b0, ic_cacheable = 1'b0;
    logic          dc_done = 1'b0, wb_empty = 1'b1;
    logic          irq = 1'b0, fiq = 1'b0, dbg_req = 1'b0;
    logic          core_stall, ic_req, dc_req, dc_kind, fill_req;
    logic          wb_drain_req, low_power, wake_ack;
    logic [1:0]    ic_kind;
    logic [DW-1:0] op_arg;
    logic [AW-1:0] wake_link;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cmaint_seq #(.DW(DW), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_crm(cmd_crm),
        .cmd_op2(cmd_op2), .cmd_data(cmd_data), .cmd_pc(cmd_pc),
        .core_stall(core_stall), .ic_req(ic_req), .ic_kind(ic_kind),
        .dc_req(dc_req), .dc_kind(dc_kind), .op_arg(op_arg),
        .ic_done(ic_done), .ic_miss(ic_miss), .ic_cacheable(ic_cacheable),
        .dc_done(dc_done), .fill_req(fill_req), .wb_drain_req(wb_drain_req),
        .wb_empty(wb_empty), .irq(irq), .fiq(fiq), .dbg_req(dbg_req),
        .low_power(low_power), .wake_ack(wake_ack), .wake_link(wake_link)
    );

    typedef struct packed {
        logic [3:0] crm;
        logic [2:0] op2;
        logic       ic;
        logic       dc;
        logic [1:0] ick;
        logic       dck;
        logic       zero;
    } vec_t;

    // Cache command table: selector, expected targets, kinds, zeroed operand
    localparam vec_t VECS [7] = '{
        '{4'd7,  3'd0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1},
        '{4'd5,  3'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1},
        '{4'd5,  3'd1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0},
        '{4'd5,  3'd2, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0},
        '{4'd13, 3'd1, 1'b1, 1'b0, 2'd3, 1'b0, 1'b0},
        '{4'd6,  3'd0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1},
        '{4'd6,  3'd1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] crm, input logic [2:0] op2,
                        input logic [DW-1:0] data, input logic [AW-1:0] pc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_crm = crm; cmd_op2 = op2; cmd_data = data; cmd_pc = pc;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_data = '0;
    endtask

    task automatic prefetch(input logic miss, input logic cach, input logic exp_fill);
        send(4'd13, 3'd1, 16'h4440, '0);
        @(negedge clk);
        ic_done = 1'b1; ic_miss = miss; ic_cacheable = cach;
        @(negedge clk);
        ic_done = 1'b0; ic_miss = 1'b0; ic_cacheable = 1'b0;
        chk("R6 fill_req", 32'(fill_req), 32'(exp_fill));
        if (exp_fill) chk("R6 fill address", 32'(op_arg), 32'h4440);
        @(negedge clk);
        chk("R6 fill pulse ends", 32'(fill_req), 0);
    endtask

    task automatic wait_cmd(input logic [AW-1:0] pc, input int src, input logic [AW-1:0] exp_link);
        wb_empty = 1'b0;
        send(4'd0, 3'd4, '0, pc);
        repeat (3) begin
            chk("R8 no sleep while draining", 32'(low_power), 0);
            chk("R8 drain requested", 32'(wb_drain_req), 1);
            @(negedge clk);
        end
        wb_empty = 1'b1;
        @(negedge clk);
        chk("R8 sleep after empty", 32'(low_power), 1);
        repeat (3) begin
            @(negedge clk);
            chk("R9 stays asleep", 32'(low_power), 1);
            chk("R9 stall while asleep", 32'(core_stall), 1);
        end
        if (src == 0) irq = 1'b1; else if (src == 1) fiq = 1'b1; else dbg_req = 1'b1;
        @(negedge clk);
        irq = 1'b0; fiq = 1'b0; dbg_req = 1'b0;
        chk("R9 woken", 32'(low_power), 0);
        chk("R9 wake_ack", 32'(wake_ack), 1);
        chk("R9 link", 32'(wake_link), 32'(exp_link));
        @(negedge clk);
        chk("R9 stall released", 32'(core_stall), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 stall in reset", 32'(core_stall), 0);
        chk("R1 low_power in reset", 32'(low_power), 0);
        chk("R1 requests in reset", 32'({ic_req, dc_req, wb_drain_req, fill_req, wake_ack}), 0);
        rst_n = 1'b1;

        // R2 R3 R4 R5: table walk
        for (int i = 0; i < 7; i++) begin
            logic [DW-1:0] d;
            d = DW'(16'hA5C0 + i);
            send(VECS[i].crm, VECS[i].op2, d, '0);
            chk("R2 ic_req", 32'(ic_req), 32'(VECS[i].ic));
            chk("R3 dc_req", 32'(dc_req), 32'(VECS[i].dc));
            if (VECS[i].ic) chk("R2 ic_kind", 32'(ic_kind), 32'(VECS[i].ick));
            if (VECS[i].dc) chk("R3 dc_kind", 32'(dc_kind), 32'(VECS[i].dck));
            chk("R4 operand", 32'(op_arg), VECS[i].zero ? 32'h0 : 32'(d));
            @(negedge clk);
            chk("R2 one-cycle request", 32'({ic_req, dc_req}), 0);
            ic_done = 1'b1; dc_done = 1'b1;
            @(negedge clk);
            ic_done = 1'b0; dc_done = 1'b0;
            chk("R5 stall after done", 32'(core_stall), 1);
            @(negedge clk);
            chk("R5 stall released", 32'(core_stall), 0);
        end

        // R5: both caches, done signals in different cycles
        send(4'd7, 3'd0, '0, '0);
        @(negedge clk);
        ic_done = 1'b1;
        @(negedge clk);
        ic_done = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk("R5 waits for data cache", 32'(core_stall), 1);
        end
        dc_done = 1'b1;
        @(negedge clk);
        dc_done = 1'b0;
        chk("R5 stall after last done", 32'(core_stall), 1);
        @(negedge clk);
        chk("R5 split done released", 32'(core_stall), 0);

        // R6: prefetch outcomes
        prefetch(1'b1, 1'b1, 1'b1);
        prefetch(1'b1, 1'b0, 1'b0);
        prefetch(1'b0, 1'b1, 1'b0);

        // R7 R12: barrier with a stray write while busy
        wb_empty = 1'b0;
        send(4'd10, 3'd4, '0, '0);
        chk("R7 drain requested", 32'(wb_drain_req), 1);
        cmd_valid = 1'b1; cmd_crm = 4'd5; cmd_op2 = 3'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R12 write ignored while stalled", 32'(ic_req), 0);
        repeat (3) begin
            @(negedge clk);
            chk("R7 held while not empty", 32'({core_stall, wb_drain_req}), 32'b11);
        end
        wb_empty = 1'b1;
        @(negedge clk);
        chk("R7 drain dropped", 32'(wb_drain_req), 0);
        chk("R7 stall one more cycle", 32'(core_stall), 1);
        chk("R7 no sleep for barrier", 32'(low_power), 0);
        @(negedge clk);
        chk("R7 stall released", 32'(core_stall), 0);
        chk("R12 no late request", 32'(ic_req), 0);

        // R8 R9: wait command with each wake source, including link wrap
        wait_cmd(16'hFFFC, 0, 16'h0004);
        wait_cmd(16'h1230, 1, 16'h1238);
        wait_cmd(16'h0100, 2, 16'h0108);

        // R10: wake during drain skips sleep
        wb_empty = 1'b0;
        send(4'd0, 3'd4, '0, 16'h2000);
        dbg_req = 1'b1;
        @(negedge clk);
        dbg_req = 1'b0;
        @(negedge clk);
        chk("R10 still draining", 32'(wb_drain_req), 1);
        wb_empty = 1'b1;
        @(negedge clk);
        chk("R10 sleep skipped", 32'(low_power), 0);
        chk("R10 wake_ack", 32'(wake_ack), 1);
        chk("R10 link", 32'(wake_link), 32'h2008);
        @(negedge clk);
        chk("R10 stall released", 32'(core_stall), 0);

        // R11: unrecognised selectors
        send(4'd3, 3'd0, 16'hFFFF, '0);
        chk("R11 no stall", 32'(core_stall), 0);
        chk("R11 no request", 32'({ic_req, dc_req, wb_drain_req, low_power}), 0);
        send(4'd5, 3'd3, 16'hFFFF, '0);
        chk("R11 no stall second", 32'(core_stall), 0);
        chk("R11 no request second", 32'({ic_req, dc_req, wb_drain_req, low_power}), 0);

        // R1: reset in the middle of a sleep
        wait_cmd(16'h0010, 0, 16'h0018);
        wb_empty = 1'b0;
        send(4'd0, 3'd4, '0, '0);
        wb_empty = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears sleep", 32'({core_stall, low_power}), 0);
        rst_n = 1'b1;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule